// File: doc/BRIEF.md
# CAN Controller Mode and Command Unit

This block is the control core of a CAN controller as software sees it through a 32-bit register port. It keeps the operating-mode register, which selects reset (configuration) mode, listen-only, loopback, single or dual acceptance filtering, and sleep. It also decodes a write-only command register into one-cycle strobes for the bit engine and the receive buffer: transmit, self-receive, abort, release receive buffer, clear overrun and bus-off. The bit engine, the filters and the message buffers live elsewhere and connect only through these strobes and a transmit-busy input.

Configuration is protected by reset mode. The bit-timing register, the sleep bit and the filter-select bit change only while the reset bit is already set. Software leaves configuration by writing the reset bit to 0 and polls the mode register until the value reads back. A zero written to the error-counter address while in reset mode asks the error logic to clear its counters and its captured error code.

Top module: `can_ctl_top`

## Requirements
- R1: After reset the mode register reads 0x00000001 (reset mode set, all other mode bits 0), the timing register reads 0, and every strobe output is low.
- R2: The mode register sits at word address 0. Bit 0 is reset mode, bit 1 listen-only, bit 2 loopback, bit 3 single filter (0 selects dual filters), bit 4 sleep. The bits drive the matching outputs, and a read returns them in those positions with bits 31..5 zero. Writing bit 0 as 0 leaves reset mode, and the bit reads back as written.
- R3: A mode write changes the sleep bit and the single-filter bit only if the reset bit was 1 before that write. Otherwise both keep their values.
- R4: If a mode write sets both bit 1 and bit 2, loopback is set and listen-only is cleared. The two outputs are never high together.
- R5: The bit-timing register at word address 2 stores the low 24 bits of a write only while reset mode is set. Writes at other times are dropped. Reads return the stored value with bits 31..24 zero.
- R6: A write to the command register at word address 1 produces, in the cycle after the write edge, a one-cycle pulse on each output whose bit is 1: bit 0 transmit, bit 1 abort, bit 2 release receive buffer, bit 3 clear overrun, bit 4 self-receive, bit 5 bus-off. Without a command write, no strobe is high.
- R7: The command register stores nothing and reads as zero.
- R8: The transmit and self-receive bits of a command write are dropped when reset mode is set or the transmit-busy input is high in the write cycle. The other bits of the same write still pulse.
- R9: A write of exactly zero to word address 3 while in reset mode produces a one-cycle error-clear pulse in the next cycle. A nonzero value, or any write there outside reset mode, produces none. The address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| addr | input | 2 | Word address for write and read |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr (combinational) |
| txBusy | input | 1 | Transmitter is busy with a frame |
| txReq | output | 1 | Transmit request strobe |
| abortReq | output | 1 | Abort transmission strobe |
| releaseRxBuf | output | 1 | Release receive buffer strobe |
| clearOverrun | output | 1 | Clear overrun flag strobe |
| selfRxReq | output | 1 | Self-receive request strobe |
| busOffReq | output | 1 | Bus-off request strobe |
| errClear | output | 1 | Error counter and error-code clear strobe |
| resetMode | output | 1 | Reset (configuration) mode active |
| listenOnly | output | 1 | Listen-only mode |
| loopback | output | 1 | Loopback mode |
| singleFilter | output | 1 | Single acceptance filter selected |
| sleepMode | output | 1 | Sleep mode |
| bitTiming | output | 24 | Stored bit-timing configuration |

## Verification
The case of interest is a command write that carries a transmit or self-receive bit together with abort, release or bus-off bits, in a cycle where the transmit-busy input is high or reset mode is set. The suppression must then drop only the two transmit-type strobes while the rest still pulse. The bench drives these mixed writes directly and in a long stretch of random traffic that toggles the busy input and reset mode. Each cycle, a behavioural reference model computes every strobe and readback, and these are compared with the outputs half a clock after each edge.

// File: rtl/can_ctl_pkg.sv
package can_ctl_pkg;

  // Word addresses of the register port
  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_CMD    = 2'd1;
  localparam logic [1:0] ADDR_TIMING = 2'd2;
  localparam logic [1:0] ADDR_ERRCNT = 2'd3;

  localparam int MODE_BITS = 5;
  localparam int CMD_BITS  = 6;

  // Packed so that the LSB matches bit 0 of the written word
  typedef struct packed {
    logic sleep;
    logic singleFilter;
    logic loopback;
    logic listenOnly;
    logic resetMode;
  } modeBits_t;

  typedef struct packed {
    logic busOff;
    logic selfRx;
    logic clrOverrun;
    logic releaseRx;
    logic abort;
    logic tx;
  } cmdBits_t;

  // Control-to-datapath write strobes
  typedef struct packed {
    logic mode;
    logic cmd;
    logic timing;
    logic errc;
  } wrStrobes_t;

endpackage

// File: rtl/can_ctl_decode.sv
module can_ctl_decode
  import can_ctl_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] addr,
  output wrStrobes_t wrS
);

  always_comb begin
    wrS        = '0;
    wrS.mode   = wrEn && (addr == ADDR_MODE);
    wrS.cmd    = wrEn && (addr == ADDR_CMD);
    wrS.timing = wrEn && (addr == ADDR_TIMING);
    wrS.errc   = wrEn && (addr == ADDR_ERRCNT);
  end

endmodule

// File: rtl/can_ctl_regs.sv
module can_ctl_regs
  import can_ctl_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TIMING_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobes_t          wrS,
  input  logic [1:0]          addr,
  input  logic [TIMING_W-1:0] wrLow,
  output modeBits_t           modeQ,
  output logic [TIMING_W-1:0] timingQ,
  output logic [DATA_W-1:0]   rdData
);

  localparam int MODE_PAD   = DATA_W - MODE_BITS;
  localparam int TIMING_PAD = DATA_W - TIMING_W;

  modeBits_t modeNext;
  modeBits_t wrMode;

  assign wrMode = modeBits_t'(wrLow[MODE_BITS-1:0]);

  always_comb begin
    modeNext = modeQ;
    if (wrS.mode) begin
      modeNext.resetMode  = wrMode.resetMode;
      modeNext.loopback   = wrMode.loopback;
      modeNext.listenOnly = wrMode.listenOnly && !wrMode.loopback;
      if (modeQ.resetMode) begin
        modeNext.sleep        = wrMode.sleep;
        modeNext.singleFilter = wrMode.singleFilter;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= '{resetMode: 1'b1, default: 1'b0};
      timingQ <= '0;
    end else begin
      modeQ <= modeNext;
      if (wrS.timing && modeQ.resetMode) timingQ <= wrLow;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_MODE:   rdData = {{MODE_PAD{1'b0}}, modeQ};
      ADDR_TIMING: rdData = {{TIMING_PAD{1'b0}}, timingQ};
      default:     rdData = '0;
    endcase
  end

  // R3: sleep and filter select frozen when written outside reset mode
  a_r3_lock_outside_reset: assert property (@(posedge clk) disable iff (!rstN)
    (wrS.mode && !modeQ.resetMode) |=> ($stable(modeQ.sleep) && $stable(modeQ.singleFilter)));

  // R4: listen-only and loopback exclusive
  a_r4_modes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(modeQ.listenOnly && modeQ.loopback));

  // R5: timing held outside reset mode
  a_r5_timing_locked: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ.resetMode |=> $stable(timingQ));

  // R5: timing changes only through a timing write
  a_r5_timing_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    !wrS.timing |=> $stable(timingQ));

endmodule

// File: rtl/can_ctl_cmd.sv
module can_ctl_cmd
  import can_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobes_t        wrS,
  input  logic [DATA_W-1:0] wrData,
  input  logic              inReset,
  input  logic              txBusy,
  output cmdBits_t          cmdQ,
  output logic              errClearQ
);

  cmdBits_t cmdGated;
  logic     txBlocked;

  assign txBlocked = inReset || txBusy;

  always_comb begin
    cmdGated = cmdBits_t'(wrData[CMD_BITS-1:0]);
    if (txBlocked) begin
      cmdGated.tx     = 1'b0;
      cmdGated.selfRx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ      <= '0;
      errClearQ <= 1'b0;
    end else begin
      cmdQ      <= wrS.cmd ? cmdGated : '0;
      errClearQ <= wrS.errc && inReset && (wrData == '0);
    end
  end

  // R6: no strobe without a command write
  a_r6_strobe_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    !wrS.cmd |=> (cmdQ == '0));

  // R8: transmit-type strobes suppressed in reset mode or while busy
  a_r8_tx_suppressed: assert property (@(posedge clk) disable iff (!rstN)
    (wrS.cmd && (inReset || txBusy)) |=> (!cmdQ.tx && !cmdQ.selfRx));

  // R9: error clear only after an error-counter write in reset mode
  a_r9_clear_needs_reset_write: assert property (@(posedge clk) disable iff (!rstN)
    !(wrS.errc && inReset) |=> !errClearQ);

endmodule

// File: rtl/can_ctl_top.sv
module can_ctl_top
  import can_ctl_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TIMING_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic                txBusy,
  output logic                txReq,
  output logic                abortReq,
  output logic                releaseRxBuf,
  output logic                clearOverrun,
  output logic                selfRxReq,
  output logic                busOffReq,
  output logic                errClear,
  output logic                resetMode,
  output logic                listenOnly,
  output logic                loopback,
  output logic                singleFilter,
  output logic                sleepMode,
  output logic [TIMING_W-1:0] bitTiming
);

  wrStrobes_t wrS;
  modeBits_t  modeQ;
  cmdBits_t   cmdQ;

  can_ctl_decode uDecode (
    .wrEn (wrEn),
    .addr (addr),
    .wrS  (wrS)
  );

  can_ctl_regs #(.DATA_W(DATA_W), .TIMING_W(TIMING_W)) uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .wrS     (wrS),
    .addr    (addr),
    .wrLow   (wrData[TIMING_W-1:0]),
    .modeQ   (modeQ),
    .timingQ (bitTiming),
    .rdData  (rdData)
  );

  can_ctl_cmd #(.DATA_W(DATA_W)) uCmd (
    .clk       (clk),
    .rstN      (rstN),
    .wrS       (wrS),
    .wrData    (wrData),
    .inReset   (modeQ.resetMode),
    .txBusy    (txBusy),
    .cmdQ      (cmdQ),
    .errClearQ (errClear)
  );

  assign txReq        = cmdQ.tx;
  assign abortReq     = cmdQ.abort;
  assign releaseRxBuf = cmdQ.releaseRx;
  assign clearOverrun = cmdQ.clrOverrun;
  assign selfRxReq    = cmdQ.selfRx;
  assign busOffReq    = cmdQ.busOff;

  assign resetMode    = modeQ.resetMode;
  assign listenOnly   = modeQ.listenOnly;
  assign loopback     = modeQ.loopback;
  assign singleFilter = modeQ.singleFilter;
  assign sleepMode    = modeQ.sleep;

endmodule

// File: tb/can_ctl_top_test.sv
module can_ctl_top_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [1:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        txBusy;
  logic        txReq, abortReq, releaseRxBuf, clearOverrun, selfRxReq, busOffReq;
  logic        errClear, resetMode, listenOnly, loopback, singleFilter, sleepMode;
  logic [23:0] bitTiming;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [4:0]  mMode;
  logic [23:0] mTiming;
  logic [5:0]  mCmd;
  logic        mErr;

  always #4 clk = ~clk;

  can_ctl_top uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .txBusy(txBusy), .txReq(txReq), .abortReq(abortReq),
    .releaseRxBuf(releaseRxBuf), .clearOverrun(clearOverrun),
    .selfRxReq(selfRxReq), .busOffReq(busOffReq), .errClear(errClear),
    .resetMode(resetMode), .listenOnly(listenOnly), .loopback(loopback),
    .singleFilter(singleFilter), .sleepMode(sleepMode), .bitTiming(bitTiming)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRead(logic [1:0] a);
    case (a)
      2'd0:    return {27'd0, mMode};
      2'd2:    return {8'd0, mTiming};
      default: return 32'd0;
    endcase
  endfunction

  task automatic compareAll(string tagMode);
    check("R2", {27'd0, sleepMode, singleFilter, loopback, listenOnly, resetMode},
          {27'd0, mMode}, {"mode outputs ", tagMode});
    check("R4", {31'd0, listenOnly & loopback}, 32'd0, "listen and loopback together");
    check("R5", {8'd0, bitTiming}, {8'd0, mTiming}, "bit timing");
    check("R8", {30'd0, selfRxReq, txReq}, {30'd0, mCmd[4], mCmd[0]}, "transmit strobes");
    check("R6", {28'd0, busOffReq, clearOverrun, releaseRxBuf, abortReq},
          {28'd0, mCmd[5], mCmd[3], mCmd[2], mCmd[1]}, "other strobes");
    check("R9", {31'd0, errClear}, {31'd0, mErr}, "error clear");
    check(addr == 2'd1 ? "R7" : "R2", rdData, expRead(addr), "read data");
  endtask

  // one clock: drive, let the edge happen, update model, compare at negedge
  task automatic step(bit we, logic [1:0] a, logic [31:0] d, bit busy, string tag);
    logic [4:0] nm;
    wrEn = we; addr = a; wrData = d; txBusy = busy;
    @(posedge clk);
    mCmd = '0;
    mErr = 1'b0;
    if (we) begin
      case (a)
        2'd0: begin
          nm    = mMode;
          nm[0] = d[0];
          nm[2] = d[2];
          nm[1] = d[1] && !d[2];
          if (mMode[0]) begin
            nm[3] = d[3];
            nm[4] = d[4];
          end
          mMode = nm;
        end
        2'd1: begin
          mCmd = d[5:0];
          if (mMode[0] || busy) begin
            mCmd[0] = 1'b0;
            mCmd[4] = 1'b0;
          end
        end
        2'd2: if (mMode[0]) mTiming = d[23:0];
        default: mErr = mMode[0] && (d == 32'd0);
      endcase
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; addr = 2'd0; wrData = '0; txBusy = 1'b0;
    mMode = 5'b00001; mTiming = '0; mCmd = '0; mErr = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", rdData, 32'h1, "mode readback after reset");
    check("R1", {8'd0, bitTiming}, 32'd0, "timing after reset");
    check("R1", {25'd0, errClear, busOffReq, selfRxReq, clearOverrun, releaseRxBuf,
                 abortReq, txReq}, 32'd0, "strobes after reset");
    rstN = 1'b1;
    step(0, 2'd0, 0, 0, "R1 idle");

    // R5: timing write in reset mode, readback
    step(1, 2'd2, 32'hDEAD_BEEF, 0, "R5 write");
    step(0, 2'd2, 0, 0, "R5 read");
    // R9: zero write in reset mode pulses; nonzero does not
    step(1, 2'd3, 32'd0, 0, "R9 zero");
    step(1, 2'd3, 32'd5, 0, "R9 nonzero");
    // R8: commands in reset mode: tx/self dropped, abort+bus-off pulse
    step(1, 2'd1, 32'h3F, 0, "R8 reset");
    step(0, 2'd1, 0, 0, "R7 read");
    // R3: set sleep + single filter while in reset
    step(1, 2'd0, 32'h19, 0, "R3 set");
    // R2: leave reset, clear sleep in same write (allowed: was in reset)
    step(1, 2'd0, 32'h08, 0, "R2 leave reset");
    step(0, 2'd0, 0, 0, "R2 readback");
    // R3: attempt sleep/filter change outside reset mode
    step(1, 2'd0, 32'h10, 0, "R3 locked");
    // R4: both listen and loopback
    step(1, 2'd0, 32'h06, 0, "R4 both");
    step(1, 2'd0, 32'h02, 0, "R4 listen");
    // R5: timing write outside reset is dropped
    step(1, 2'd2, 32'h0012_3456, 0, "R5 locked");
    // R9: zero write outside reset does nothing
    step(1, 2'd3, 32'd0, 0, "R9 normal");
    // R6: transmit pulse, single cycle
    step(1, 2'd1, 32'h01, 0, "R6 tx");
    step(0, 2'd1, 0, 0, "R6 tx ends");
    // R8: tx + abort with busy high
    step(1, 2'd1, 32'h13, 1, "R8 busy");
    // R6: each bit alone, back to back
    for (int b = 0; b < 6; b++) step(1, 2'd1, 32'd1 << b, 0, "R6 single bit");
    step(1, 2'd1, 32'h3F, 0, "R6 all bits");
    // back to reset mode
    step(1, 2'd0, 32'h01, 0, "R2 enter reset");
    step(1, 2'd2, 32'h00AB_CDEF, 0, "R5 rewrite");

    // random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [31:0] d;
      r = $urandom;
      d = $urandom;
      if (r[5:4] == 2'd3) d = 32'd0;
      if (r[1:0] == 2'd0) d = d & 32'h1F;
      step(r[2], r[1:0], d, r[3], "random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule